// File: doc/BRIEF.md
# Comma-Aligned Receive Character Framer

This block sits behind a bit-rate serial receive path and cuts the incoming bit stream into ten-bit characters. A free-running modulo-ten bit counter decides when a character is complete. A ten-bit sliding window looks at the newest ten bits on every bit clock. When that window holds either running-disparity form of the K28.5 comma, and realignment is enabled, the counter is restarted so that the comma closes a character. The bytes that follow are then framed from that point.

Realignment can be switched off. A corrupted stream can then not produce a false comma that moves the boundaries. When realignment is switched back on, the framed status drops and stays low until a genuine comma is seen. Characters keep flowing out the whole time. Clock recovery and 8b/10b decoding are done elsewhere; the block gets a bit-rate clock and one serial bit per clock.

The block has two framing states. SEEK means it is waiting for a comma. SYNC means it is framed. Three transitions move between them: reset→SEEK; SEEK→SYNC on an accepted comma; SYNC→SEEK on a rising edge of the realign enable in a cycle with no accepted comma.

Top module: `comma_framer`

## Requirements
- R1: While rst_n is low, and after it is released until the first character completes, char_vld and framed are 0 and char_out is 0. The bit counter starts at its initial phase, so the 10th bit clocked after reset completes the first character.
- R2: Without comma realignment, char_vld pulses for one cycle every 10 bit clocks. The pulse comes in the cycle after the edge that takes in the 10th bit. char_out then holds those ten bits, with the first received bit (a) in char_out[9] and the last (j) in char_out[0].
- R3: With realign_en high, a window equal to 10'b0011111010 or 10'b1100000101 (char_out bit order) at any bit offset completes a character at once. The comma appears on char_out with char_vld, and the next character completes 10 bits later.
- R4: A comma that already falls on the current character boundary leaves the 10-bit character rhythm unchanged, with no extra or missing char_vld pulse.
- R5: With realign_en low, a comma does not restart the counter. No char_vld occurs off the existing boundaries, and characters keep their old alignment.
- R6: framed rises, together with char_vld, only when a comma is accepted with realign_en high (SEEK→SYNC).
- R7: A rising edge of realign_en clears framed in the next cycle (SYNC→SEEK), unless a comma is accepted on that same edge, in which case framed is 1.
- R8: While framed is 0, received characters are still delivered with char_vld on every boundary.
- R9: While realign_en is low, framed does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Received serial bit, one per clock |
| realign_en | input | 1 | Allows a detected comma to realign the counter |
| char_out | output | W | Last completed character, bit a in the MSB |
| char_vld | output | 1 | One-cycle strobe for a new character |
| framed | output | 1 | High once a comma has set the framing (SYNC) |

## Verification
Every result is registered once. char_out, char_vld and framed change on the same edge that takes in the 10th bit of a character, or the last bit of a comma. The bench drives each bit at a falling edge and samples 1 ns after the following rising edge, so each check reads exactly the cycle in which the result is due. A drop of framed after a realign_en rise is due one edge after the rise. A boundary that must not produce a strobe is checked by sampling char_vld after each of the nine preceding bits.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int CHAR_W = 10;
    localparam int N_COMMA = 2;
    // both disparity forms of K28.5, first received bit in the MSB
    localparam logic [CHAR_W-1:0] COMMA_RDN = 10'b0011111010;
    localparam logic [CHAR_W-1:0] COMMA_RDP = 10'b1100000101;

    typedef enum logic {
        ST_SEEK,
        ST_SYNC
    } frm_state_t;
endpackage

// File: rtl/cfr_window.sv
module cfr_window #(
    parameter int W = cfr_pkg::CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_bit,
    output logic [W-1:0] nxt_win
);
    logic [W-1:0] win_q;

    assign nxt_win = {win_q[W-2:0], ser_bit};

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= nxt_win;
    end
endmodule

// File: rtl/cfr_comma_det.sv
module cfr_comma_det #(
    parameter int W = cfr_pkg::CHAR_W
) (
    input  logic [W-1:0] win,
    output logic         hit
);
    localparam logic [W-1:0] PATS [cfr_pkg::N_COMMA] =
        '{cfr_pkg::COMMA_RDN, cfr_pkg::COMMA_RDP};

    logic [cfr_pkg::N_COMMA-1:0] match;

    for (genvar p = 0; p < cfr_pkg::N_COMMA; p++) begin : g_pat
        assign match[p] = (win == PATS[p]);
    end

    assign hit = |match;
endmodule

// File: rtl/cfr_bit_cnt.sv
module cfr_bit_cnt #(
    parameter int W = cfr_pkg::CHAR_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == LAST_PH);

    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (last || restart) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cfr_frame_fsm.sv
module cfr_frame_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic realign_en,
    input  logic accept,
    output logic framed
);
    import cfr_pkg::*;

    frm_state_t state_q, state_nxt;
    logic       en_q;
    logic       en_rise;

    assign en_rise = realign_en && !en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_nxt;
            en_q    <= realign_en;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_SEEK: if (accept)             state_nxt = ST_SYNC;
            ST_SYNC: if (en_rise && !accept) state_nxt = ST_SEEK;
        endcase
    end

    always_comb begin
        framed = (state_q == ST_SYNC);
    end
endmodule

// File: rtl/comma_framer.sv
module comma_framer #(
    parameter int W = cfr_pkg::CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_bit,
    input  logic         realign_en,
    output logic [W-1:0] char_out,
    output logic         char_vld,
    output logic         framed
);
    logic [W-1:0] nxt_win;
    logic         comma_hit;
    logic         cnt_last;
    logic         accept;
    logic         load;
    logic [W-1:0] char_q;
    logic         vld_q;

    cfr_window #(.W(W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .nxt_win (nxt_win)
    );

    cfr_comma_det #(.W(W)) u_det (
        .win (nxt_win),
        .hit (comma_hit)
    );

    assign accept = comma_hit && realign_en;
    assign load   = cnt_last || accept;

    cfr_bit_cnt #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .last    (cnt_last)
    );

    cfr_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .realign_en (realign_en),
        .accept     (accept),
        .framed     (framed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= load;
            if (load) char_q <= nxt_win;
        end
    end

    assign char_out = char_q;
    assign char_vld = vld_q;
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int W = cfr_pkg::CHAR_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         realign_en,
    input logic         comma_hit,
    input logic         cnt_last,
    input logic [W-1:0] char_out,
    input logic         char_vld,
    input logic         framed
);
    // R2: a full count always produces a character strobe
    a_r2_last_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_last |=> char_vld);

    // R3: an accepted comma is delivered and frames the link
    a_r3_comma_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_en && comma_hit) |=> (char_vld && framed &&
            (char_out == cfr_pkg::COMMA_RDN || char_out == cfr_pkg::COMMA_RDP)));

    // R5: with realignment off, no strobe off the boundary
    a_r5_no_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign_en && !cnt_last) |=> !char_vld);

    // R6: framed rises only after an accepted comma
    a_r6_rise_needs_comma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(framed) |-> $past(realign_en && comma_hit));

    // R7: enable edge without comma unframes
    a_r7_rise_unframes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(realign_en) && !comma_hit) |=> !framed);

    // R9: framed held while realignment is off
    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !realign_en |=> $stable(framed));
endmodule

bind comma_framer cfr_checker #(.W(W)) u_cfr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .realign_en (realign_en),
    .comma_hit  (comma_hit),
    .cnt_last   (cnt_last),
    .char_out   (char_out),
    .char_vld   (char_vld),
    .framed     (framed)
);

// File: tb/test_comma_framer.sv
`timescale 1ns/1ps
module test_comma_framer;
    localparam int W = 10;
    localparam int NV = 9;
    localparam int WDOG = 20000;
    // {realign_en, expected framed, character}
    localparam logic [W+1:0] VEC [NV] = '{
        {1'b1, 1'b1, 10'b1011001010},
        {1'b1, 1'b1, 10'b0110100110},
        {1'b1, 1'b1, 10'b1100000101},   // aligned comma, R4
        {1'b0, 1'b1, 10'b0101100101},
        {1'b0, 1'b1, 10'b1100101101},
        {1'b1, 1'b0, 10'b1011001010},   // enable rise, R7 R8
        {1'b1, 1'b0, 10'b0110100110},
        {1'b1, 1'b1, 10'b0011111010},   // aligned comma, R6
        {1'b1, 1'b1, 10'b0101100101}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_bit = 1'b0;
    logic         realign_en = 1'b0;
    logic [W-1:0] char_out;
    logic         char_vld;
    logic         framed;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int mid_vld = 0;

    always #2 clk = ~clk;

    comma_framer #(.W(W)) i_comma_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_bit    (ser_bit),
        .realign_en (realign_en),
        .char_out   (char_out),
        .char_vld   (char_vld),
        .framed     (framed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic en);
        @(negedge clk);
        ser_bit = b;
        realign_en = en;
        @(posedge clk);
        #1;
    endtask

    // nine bits with en_a, the last bit with en_b; counts strobes before the last bit
    task automatic send_char(input logic [W-1:0] c, input logic en_a, input logic en_b);
        mid_vld = 0;
        for (int k = W - 1; k >= 0; k--) begin
            send_bit(c[k], (k == 0) ? en_b : en_a);
            if (k != 0 && char_vld) mid_vld++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 vld", char_vld, 0);
        chk("R1 framed", framed, 0);
        chk("R1 char", char_out, 0);
        rst_n = 1'b1;

        // R2 first character after reset, realignment off
        send_char(10'b1011001010, 1'b0, 1'b0);
        chk("R2 vld", char_vld, 1);
        chk("R2 char", char_out, 10'b1011001010);
        chk("R2 no early strobe", mid_vld, 0);
        chk("R1 unframed", framed, 0);

        // R3 comma at an offset of three bits
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
        send_char(10'b0011111010, 1'b1, 1'b1);
        chk("R3 vld", char_vld, 1);
        chk("R3 char", char_out, 10'b0011111010);
        chk("R6 framed", framed, 1);

        // table walk: R2 R4 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            send_char(VEC[i][W-1:0], VEC[i][W+1], VEC[i][W+1]);
            chk("R2 R4 R8 vld", char_vld, 1);
            chk("R2 char", char_out, VEC[i][W-1:0]);
            chk("R6 R7 R9 framed", framed, VEC[i][W]);
            chk("R4 no extra strobe", mid_vld, 0);
        end

        // R5 misaligned comma ignored while realignment off
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        send_char(10'b0011111010, 1'b0, 1'b0);
        chk("R5 no strobe at comma", char_vld, 0);
        chk("R5 old boundary strobed", mid_vld, 1);
        send_char({7'b0110100, 3'b000}, 1'b0, 1'b0);
        // only the first 7 of those bits were needed; the boundary fell after 7
        chk("R9 framed held", framed, 1);
        chk("R5 alignment kept", mid_vld, 1);
        // stream so far: boundary was at the 7th bit of the last call
        // realign the bench to that: three bits since boundary
        send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        chk("R5 vld", char_vld, 1);
        chk("R5 char", char_out, 10'b0000110101);

        // R7 rise unframes, then rise together with a comma frames
        send_char(10'b0110100110, 1'b1, 1'b1);
        chk("R7 unframed", framed, 0);
        chk("R8 vld", char_vld, 1);
        send_char(10'b1011001010, 1'b0, 1'b0);
        chk("R9 stays unframed", framed, 0);
        send_char(10'b1100000101, 1'b0, 1'b1);
        chk("R7 same-edge comma", framed, 1);
        chk("R3 char", char_out, 10'b1100000101);

        // R3 comma four bits off boundary, next char 10 bits later
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1);
        send_char(10'b0011111010, 1'b1, 1'b1);
        chk("R3 vld off boundary", char_vld, 1);
        chk("R3 comma out", char_out, 10'b0011111010);
        send_char(10'b0101100101, 1'b1, 1'b1);
        chk("R3 restart vld", char_vld, 1);
        chk("R3 restart char", char_out, 10'b0101100101);
        chk("R3 restart no early", mid_vld, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule